// File: doc/BRIEF.md
# Linked-list descriptor loader

This block walks a chain of DMA channel configurations stored in memory. Software leaves the address of the first configuration in a head register and pulses `start`. The loader then reads that configuration one word at a time over a request/valid read port, writes each word into the channel's working registers, and hands the channel to the transfer engine through a start/done handshake.

Each configuration is eight 32-bit words. Word 7 holds the address of the next configuration and bit 0 of word 6 marks the last one. The chain in memory is circular: the final configuration points back at the first, so the loader never meets a null pointer. It stops when it sees the last-node flag, or when a next pointer equals the head address. After the last transaction it raises a one-cycle list-done pulse. It then reloads its pointer from the head register, so a later `start` walks the same chain again from the first configuration.

Top module: `dma_chain_loader`

## Requirements
- R1: Out of reset, `busy`, `rd_req`, `xfer_start` and `list_done` are all low, and none of `rd_req`, `xfer_start` or `list_done` is ever high while `busy` is low.
- R2: `head_wr` loads `head_wdata` into the head register only while the loader is idle. A write while `busy` is high is ignored, and the next walk still begins at the previously written head.
- R3: A `start` pulse while idle makes `busy` go high in the next cycle and fetches the configuration at the head address. This takes eight reads at addresses head+0, +4, ..., +28. `rd_req` is a one-cycle pulse, and no new `rd_req` is issued until `rd_valid` has returned the previous word.
- R4: Word i of the fetched configuration appears on `cfg_words[32*i+31:32*i]` and is valid when `xfer_start` is raised.
- R5: After the eighth word arrives, `xfer_start` pulses for exactly one cycle. `xfer_done` has no effect during a fetch or in the cycle of the `xfer_start` pulse. No read is issued while a started transfer has not reported done.
- R6: When a transfer is done and the current configuration has bit 0 of word 6 clear and a word-7 pointer different from the head, the next fetch begins at the word-7 address.
- R7: When the transfer of a configuration with bit 0 of word 6 set is done, `list_done` pulses for one cycle, two cycles after the cycle in which `xfer_done` was high. `busy` is low from the following cycle on.
- R8: A word-7 pointer equal to the head address ends the walk in the same way as the last-node flag, even when bit 0 of word 6 is clear.
- R9: After `list_done`, a new `start` with no head write walks the chain again from the head address.
- R10: A `start` pulse while `busy` is high has no effect on the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| head_wr | input | 1 | Write strobe for the head register (accepted only while idle) |
| head_wdata | input | 32 | Address of the first configuration |
| start | input | 1 | Begin walking the chain (accepted only while idle) |
| busy | output | 1 | High from the cycle after an accepted start until the walk ends |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | 32 | Byte address of the requested word |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 32 | Read data |
| xfer_start | output | 1 | One-cycle start pulse to the transfer engine |
| xfer_done | input | 1 | Transfer engine reports the transaction finished |
| cfg_words | output | 256 | Working registers, word i in bits 32*i+31:32*i |
| list_done | output | 1 | One-cycle pulse when the last transaction of the chain is done |

## Verification
The assertions check, on every cycle, that the port stays quiet while idle, that only one read is ever outstanding, that successive read addresses within a configuration step by four, that a transfer is started only after a whole configuration has been read, and that no fetch or list-done overlaps a running transfer. The bench's sweeps over chain lengths and both ways of ending a walk show the rest. Those runs cover where each chain actually goes, the words seen on `cfg_words` at every transfer start, and the two-cycle list-done latency. They also cover head writes and start pulses that are ignored while busy, and the restart from the head.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_FETCH = 3'd1,
      ST_RUN   = 3'd2,
      ST_NEXT  = 3'd3,
      ST_DONE  = 3'd4
   } ld_state_e;
endpackage

// File: rtl/dcl_word_addr.sv
module dcl_word_addr #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 3,
   parameter int STRIDE = 4
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);
   localparam bit POW2  = (STRIDE & (STRIDE - 1)) == 0;
   localparam int SHIFT = $clog2(STRIDE);

   generate
      if (POW2) begin : g_shift
         assign addr = base + (ADDR_W'(idx) << SHIFT);
      end else begin : g_mult
         assign addr = base + ADDR_W'(idx) * ADDR_W'(STRIDE);
      end
   endgenerate
endmodule

// File: rtl/dcl_cfg_store.sv
module dcl_cfg_store #(
   parameter int DATA_W = 32,
   parameter int WORDS  = 8,
   parameter int IDX_W  = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [IDX_W-1:0]        wr_idx,
   input  logic [DATA_W-1:0]       wr_data,
   output logic [WORDS*DATA_W-1:0] words_flat
);
   logic [DATA_W-1:0] word_q [WORDS];

   generate
      for (genvar w = 0; w < WORDS; w++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               word_q[w] <= '0;
            else if (wr_en && wr_idx == IDX_W'(w))
               word_q[w] <= wr_data;
         end
         assign words_flat[w*DATA_W +: DATA_W] = word_q[w];
      end
   endgenerate
endmodule

// File: rtl/dcl_end_check.sv
module dcl_end_check #(
   parameter int ADDR_W     = 32,
   parameter bit HEAD_MATCH = 1'b1
) (
   input  logic              last_flag,
   input  logic [ADDR_W-1:0] next_ptr,
   input  logic [ADDR_W-1:0] head,
   output logic              is_last
);
   generate
      if (HEAD_MATCH) begin : g_with_wrap
         assign is_last = last_flag || (next_ptr == head);
      end else begin : g_flag_only
         logic unused_ok;
         assign unused_ok = ^{next_ptr, head};
         assign is_last   = last_flag;
      end
   endgenerate
endmodule

// File: rtl/dma_chain_loader.sv
module dma_chain_loader #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int WORDS      = 8,
   parameter int NEXT_IDX   = WORDS - 1,
   parameter int FLAG_IDX   = WORDS - 2,
   parameter int FLAG_BIT   = 0,
   parameter int STRIDE     = DATA_W / 8,
   parameter bit HEAD_MATCH = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    head_wr,
   input  logic [ADDR_W-1:0]       head_wdata,
   input  logic                    start,
   output logic                    busy,
   output logic                    rd_req,
   output logic [ADDR_W-1:0]       rd_addr,
   input  logic                    rd_valid,
   input  logic [DATA_W-1:0]       rd_data,
   output logic                    xfer_start,
   input  logic                    xfer_done,
   output logic [WORDS*DATA_W-1:0] cfg_words,
   output logic                    list_done
);
   import dcl_pkg::*;

   localparam int IDX_W = $clog2(WORDS);

   generate
      if (WORDS < 2) begin : g_err_words
         $error("WORDS must be at least 2");
      end
      if (NEXT_IDX >= WORDS || FLAG_IDX >= WORDS || NEXT_IDX == FLAG_IDX) begin : g_err_idx
         $error("NEXT_IDX and FLAG_IDX must be distinct words of the configuration");
      end
      if (FLAG_BIT >= DATA_W) begin : g_err_bit
         $error("FLAG_BIT outside the data word");
      end
      if (DATA_W < ADDR_W) begin : g_err_width
         $error("a data word must hold a full next pointer");
      end
      if (STRIDE < 1) begin : g_err_stride
         $error("STRIDE must be positive");
      end
   endgenerate

   ld_state_e          st_q;
   logic [ADDR_W-1:0]  head_q;
   logic [ADDR_W-1:0]  ptr_q;
   logic [IDX_W-1:0]   idx_q;
   logic               wait_q;
   logic               launched_q;
   logic               last_word;
   logic               store_en;
   logic               is_last;
   logic [ADDR_W-1:0]  next_ptr;
   logic               last_flag;

   assign last_word = (idx_q == IDX_W'(WORDS - 1));
   assign store_en  = (st_q == ST_FETCH) && wait_q && rd_valid;
   assign next_ptr  = cfg_words[NEXT_IDX*DATA_W +: ADDR_W];
   assign last_flag = cfg_words[FLAG_IDX*DATA_W + FLAG_BIT];

   dcl_word_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .STRIDE(STRIDE)) u_addr (
      .base (ptr_q),
      .idx  (idx_q),
      .addr (rd_addr)
   );

   dcl_cfg_store #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (store_en),
      .wr_idx     (idx_q),
      .wr_data    (rd_data),
      .words_flat (cfg_words)
   );

   dcl_end_check #(.ADDR_W(ADDR_W), .HEAD_MATCH(HEAD_MATCH)) u_end (
      .last_flag (last_flag),
      .next_ptr  (next_ptr),
      .head      (head_q),
      .is_last   (is_last)
   );

   // head register: software view, frozen during a walk
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         head_q <= '0;
      else if (head_wr && st_q == ST_IDLE)
         head_q <= head_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         ptr_q      <= '0;
         idx_q      <= '0;
         wait_q     <= 1'b0;
         launched_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  ptr_q  <= head_wr ? head_wdata : head_q;
                  idx_q  <= '0;
                  wait_q <= 1'b0;
                  st_q   <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (!wait_q) begin
                  wait_q <= 1'b1;
               end else if (rd_valid) begin
                  wait_q <= 1'b0;
                  if (last_word) begin
                     launched_q <= 1'b0;
                     st_q       <= ST_RUN;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            ST_RUN: begin
               if (!launched_q)
                  launched_q <= 1'b1;
               else if (xfer_done)
                  st_q <= ST_NEXT;
            end
            ST_NEXT: begin
               if (is_last) begin
                  st_q <= ST_DONE;
               end else begin
                  ptr_q  <= next_ptr;
                  idx_q  <= '0;
                  wait_q <= 1'b0;
                  st_q   <= ST_FETCH;
               end
            end
            ST_DONE: begin
               ptr_q <= head_q;
               st_q  <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (st_q != ST_IDLE);
   assign rd_req     = (st_q == ST_FETCH) && !wait_q;
   assign xfer_start = (st_q == ST_RUN) && !launched_q;
   assign list_done  = (st_q == ST_DONE);
endmodule

// File: rtl/dcl_checker.sv
module dcl_checker #(
   parameter int ADDR_W = 32,
   parameter int WORDS  = 8,
   parameter int STRIDE = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              rd_req,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              rd_valid,
   input logic              xfer_start,
   input logic              xfer_done,
   input logic              list_done
);
   localparam int CNT_W = $clog2(WORDS);

   logic              outs_q;
   logic              run_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] last_addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outs_q      <= 1'b0;
         run_q       <= 1'b0;
         cnt_q       <= '0;
         last_addr_q <= '0;
      end else begin
         if (rd_req)
            outs_q <= 1'b1;
         else if (rd_valid)
            outs_q <= 1'b0;
         if (xfer_start)
            run_q <= 1'b1;
         else if (xfer_done)
            run_q <= 1'b0;
         if (rd_req) begin
            last_addr_q <= rd_addr;
            cnt_q       <= (cnt_q == CNT_W'(WORDS - 1)) ? '0 : cnt_q + 1'b1;
         end
      end
   end

   // R1: idle port is quiet
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!rd_req && !xfer_start && !list_done));

   // R3: one read outstanding at a time
   a_r3_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> !outs_q);

   // R3: addresses within a configuration step by the word size
   a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && cnt_q != '0) |-> (rd_addr == last_addr_q + ADDR_W'(STRIDE)));

   // R5: transfer starts only after a complete configuration
   a_r5_start_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |-> (cnt_q == '0 && !outs_q));

   // R5: start is a single-cycle pulse
   a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> !xfer_start);

   // R5: no fetch and no list-done while a transfer is running
   a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req || list_done) |-> !run_q);

   // R7: list-done is one cycle and the loader is idle after it
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      list_done |=> (!list_done && !busy));
endmodule

bind dma_chain_loader dcl_checker #(
   .ADDR_W (ADDR_W),
   .WORDS  (WORDS),
   .STRIDE (STRIDE)
) u_dcl_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .rd_req     (rd_req),
   .rd_addr    (rd_addr),
   .rd_valid   (rd_valid),
   .xfer_start (xfer_start),
   .xfer_done  (xfer_done),
   .list_done  (list_done)
);

// File: tb/dma_chain_loader_bench.sv
`timescale 1ns/1ps
module dma_chain_loader_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         head_wr = 1'b0;
   logic [31:0]  head_wdata = '0;
   logic         start = 1'b0;
   logic         busy;
   logic         rd_req;
   logic [31:0]  rd_addr;
   logic         rd_valid = 1'b0;
   logic [31:0]  rd_data = '0;
   logic         xfer_start;
   logic         xfer_done = 1'b0;
   logic [255:0] cfg_words;
   logic         list_done;

   always #2 clk = ~clk;

   dma_chain_loader u_dma_chain_loader (
      .clk(clk), .rst_n(rst_n), .head_wr(head_wr), .head_wdata(head_wdata),
      .start(start), .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_valid(rd_valid), .rd_data(rd_data), .xfer_start(xfer_start),
      .xfer_done(xfer_done), .cfg_words(cfg_words), .list_done(list_done)
   );

   logic [31:0] mem [0:255];
   logic [31:0] addr_log [0:255];
   int checks = 0, fails = 0;
   int cyc = 0, nreq = 0, xs_cnt = 0, ld_cnt = 0, ld_lat = -1, done_cyc = 0;
   int outs_err = 0, cfg_err = 0, run_err = 0;
   bit rsp_pend = 0, run_pend = 0, glitch = 0;
   int rsp_wait = 0, run_wait = 0;
   logic [31:0] rsp_addr = '0;

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] node_base(input int s, input int k);
      return 32'(((s + 5 * k) % 32) * 32);
   endfunction

   // responder and monitor: all bench-side reactions happen at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         rd_valid  = 1'b0;
         xfer_done = 1'b0;
         if (rsp_pend) begin
            if (rsp_wait == 0) begin
               rd_valid = 1'b1;
               rd_data  = mem[(rsp_addr >> 2) & 255];
               rsp_pend = 0;
            end else rsp_wait--;
         end
         if (run_pend) begin
            if (run_wait == 0) begin
               xfer_done = 1'b1;
               run_pend  = 0;
               done_cyc  = cyc;
            end else run_wait--;
         end
         if (rd_req) begin
            if (rsp_pend) outs_err++;
            if (run_pend) run_err++;
            if (nreq < 256) addr_log[nreq] = rd_addr;
            if (glitch && (nreq % 8) == 3) xfer_done = 1'b1;
            rsp_pend = 1;
            rsp_wait = nreq % 3;
            rsp_addr = rd_addr;
            nreq++;
         end
         if (xfer_start) begin
            if (nreq >= 8) begin
               for (int i = 0; i < 8; i++)
                  if (cfg_words[32*i +: 32] !== mem[((addr_log[nreq-8] >> 2) + i) & 255])
                     cfg_err++;
            end else cfg_err++;
            if (glitch) xfer_done = 1'b1;
            xs_cnt++;
            run_pend = 1;
            run_wait = xs_cnt % 4;
         end
         if (list_done) begin
            if (run_pend) run_err++;
            ld_cnt++;
            ld_lat = cyc - done_cyc;
         end
      end
   end

   // chain of L nodes starting at slot s; ends on flag (use_flag) or on wrap to head
   task automatic build_chain(input int s, input int L, input bit use_flag);
      for (int k = 0; k < L; k++) begin
         logic [31:0] b;
         b = node_base(s, k);
         for (int i = 0; i < 6; i++)
            mem[(b >> 2) + i] = 32'h5A00_0000 ^ (b << 8) ^ (32'(i) * 32'h0101_0101);
         mem[(b >> 2) + 6] = (32'hC300_0000 ^ b) & ~32'h1;
         if (k < L - 1) begin
            mem[(b >> 2) + 7] = node_base(s, k + 1);
         end else if (use_flag) begin
            mem[(b >> 2) + 6] = mem[(b >> 2) + 6] | 32'h1;
            mem[(b >> 2) + 7] = node_base(s, k + 1);
         end else begin
            mem[(b >> 2) + 7] = node_base(s, 0);
         end
      end
   endtask

   task automatic do_walk(input bit wr_head, input int s, input int L, input bit use_flag,
                          input bit disturb, input string tag);
      int t, mism;
      nreq = 0; xs_cnt = 0; ld_cnt = 0; ld_lat = -1;
      outs_err = 0; cfg_err = 0; run_err = 0;
      glitch = disturb;
      if (wr_head) begin
         @(negedge clk); head_wr = 1'b1; head_wdata = node_base(s, 0);
         @(negedge clk); head_wr = 1'b0;
      end
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk({tag, " R3 busy after start"}, busy, 1);
      if (disturb) begin
         repeat (15) @(negedge clk);
         start = 1'b1; head_wr = 1'b1; head_wdata = 32'h0000_03E0;
         @(negedge clk);
         start = 1'b0; head_wr = 1'b0;
      end
      t = 0;
      while (ld_cnt == 0 && t < 4000) begin @(negedge clk); t++; end
      repeat (3) @(negedge clk);
      glitch = 0;
      mism = 0;
      for (int k = 0; k < L; k++)
         for (int i = 0; i < 8; i++)
            if (8*k + i < nreq && addr_log[8*k + i] !== node_base(s, k) + 32'(4*i)) mism++;
      chk({tag, " R3 read count"}, nreq, 8 * L);
      chk({tag, " R3 R6 fetch addresses"}, mism, 0);
      chk({tag, " R3 single outstanding"}, outs_err, 0);
      chk({tag, " R5 transfer count"}, xs_cnt, L);
      chk({tag, " R5 no overlap"}, run_err, 0);
      chk({tag, " R4 cfg_words"}, cfg_err, 0);
      chk({tag, use_flag ? " R7 list_done count" : " R8 list_done count"}, ld_cnt, 1);
      chk({tag, " R7 list_done latency"}, ld_lat, 2);
      chk({tag, " R7 idle after"}, busy, 0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
      repeat (3) @(negedge clk);
      chk("R1 reset busy", busy, 0);
      chk("R1 reset rd_req", rd_req, 0);
      chk("R1 reset xfer_start", xfer_start, 0);
      chk("R1 reset list_done", list_done, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 idle after reset", {busy, rd_req, xfer_start, list_done}, 0);
      // sweep: chain lengths and both ways of ending
      for (int L = 1; L <= 6; L++)
         for (int f = 0; f < 2; f++) begin
            build_chain(3 * L + f, L, f == 1);
            do_walk(1'b1, 3 * L + f, L, f == 1, 1'b0, f ? "sweep flag" : "sweep wrap");
         end
      // R9: restart from head without rewrite
      do_walk(1'b0, 19, 6, 1'b0, 1'b0, "R9 restart");
      // R2 R10 R5: head write, start and early done pulses during a walk
      build_chain(7, 4, 1'b1);
      do_walk(1'b1, 7, 4, 1'b1, 1'b1, "R2 R10 disturbed");
      do_walk(1'b0, 7, 4, 1'b1, 1'b0, "R2 head kept");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule